// File: doc/BRIEF.md
# AMI Encoder with Violation Insertion

This block turns a single-rail transmit bit stream into alternate mark inversion (AMI) line symbols on two rails, one for positive pulses and one for negative pulses. Each one bit in the stream (a mark) drives a pulse, and consecutive marks take opposite polarities. Each zero bit (a space) leaves both rails low. An all-ones transmit mode replaces the incoming data with a continuous run of marks.

A separate violation-request input lets the system side deliberately corrupt the line code. The block samples this input on the falling edge of the transmit clock and detects a low-to-high transition. That transition arms one bipolar violation. The violation is placed on the next mark: that mark repeats the polarity of the previous mark instead of alternating. Polarity tracking then continues from the violating mark.

Violation insertion only operates when the block is set for single-rail input with AMI coding. Static loopback-mode inputs, combined with all-ones mode, either suppress the request or redirect it back toward the system side on a dedicated output.

Top module: `ami_violation_encoder`

## Requirements
- R1: With `all_ones_en` low, a zero on `tx_data` gives `line_pos` = 0 and `line_neg` = 0 one clock later. The two rails are never high together.
- R2: A mark (a one on `tx_data`, or any bit while `all_ones_en` is high) drives exactly one rail high one clock later. Marks without a violation alternate: a positive mark (`line_pos` = 1) follows a negative one, and the reverse.
- R3: `viol_req` is sampled on each falling clock edge. A violation is armed only by a sample of 1 that follows a sample of 0. Holding the input high arms nothing more.
- R4: An armed violation is applied to the first mark that enters at or after the rising clock edge following the arming sample. It is never applied to a space. The violating mark has the same polarity as the mark before it, and the next ordinary mark alternates from the violating mark.
- R5: Further rising edges of `viol_req` that arrive while a violation is armed but not yet applied merge into that one violation. Exactly one violating mark results.
- R6: Violation insertion is enabled only when `single_rail_en` and `ami_en` are both 1. Otherwise requests are dropped and marks keep alternating.
- R7: With `all_ones_en` high, every bit period produces a mark whatever `tx_data` carries.
- R8: With `all_ones_en` high and `lb_mode` equal to 2 (analog), 3 (remote) or 4 (inband), requests are dropped and any armed violation is cleared. Marks keep alternating.
- R9: With insertion enabled, `all_ones_en` high and `lb_mode` = 1 (digital), `viol_loop` equals the most recent falling-edge sample of `viol_req`, updated at the next rising edge. In this mode no violation reaches the line. In every other mode `viol_loop` is 0. Values 0 and 5 to 7 of `lb_mode` mean no loopback.
- R10: A clock edge with `rst_n` low drives both rails and `viol_loop` to 0 and clears any armed violation. The first mark after reset is positive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock; request sampled on the falling edge, line symbols on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_data | input | 1 | Single-rail transmit bit |
| viol_req | input | 1 | Violation request, edge-sensitive |
| single_rail_en | input | 1 | Single-rail input mode selected |
| ami_en | input | 1 | AMI line coding selected |
| all_ones_en | input | 1 | Transmit continuous marks |
| lb_mode | input | 3 | Loopback mode: 0 none, 1 digital, 2 analog, 3 remote, 4 inband, 5-7 none |
| line_pos | output | 1 | Positive-pulse rail |
| line_neg | output | 1 | Negative-pulse rail |
| viol_loop | output | 1 | Violation request returned toward the system side |

## Verification
The bound checker checks the following on every cycle:
- the two rails are never high together;
- spaces are silent and marks always produce a pulse;
- `viol_loop` is active only in the redirect mode;
- reset leaves the outputs quiet;
- polarity strictly alternates whenever insertion is disabled.

Other behaviours depend on history, so only the bench's scenarios can show them:
- one violation per rising edge and none for a held level;
- placement on the next mark across runs of spaces;
- merging of back-to-back requests;
- polarity continuing from the violating mark.

The bench sweeps every mode combination, including the reserved loopback codes, against an arithmetic reference model.

// File: rtl/ami_enc_pkg.sv
// Package: shared constants and types for the AMI violation encoder.
// Assumes: loopback mode codes are static while the block runs.
package ami_enc_pkg;

    localparam int LB_W = 3;

    localparam logic [LB_W-1:0] LB_NONE    = 3'd0;
    localparam logic [LB_W-1:0] LB_DIGITAL = 3'd1;
    localparam logic [LB_W-1:0] LB_ANALOG  = 3'd2;
    localparam logic [LB_W-1:0] LB_REMOTE  = 3'd3;
    localparam logic [LB_W-1:0] LB_INBAND  = 3'd4;

    // Result of decoding the mode inputs for the violation path.
    typedef struct packed {
        logic insert_ok;  // requests may arm a violation on the line
        logic divert;     // requests are returned to the system side
    } viol_gate_t;

endpackage

// File: rtl/ami_req_edge.sv
// Module: ami_req_edge
// Samples the violation request on the falling clock edge and flags a
// low-to-high change between two consecutive samples. The flag stays
// valid from one falling edge to the next, so it covers exactly one
// rising edge.
// Assumes: req is stable around the falling edge.
module ami_req_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic level,
    output logic rise
);

    logic samp_q;
    logic prev_q;

    // Falling-edge sampler with a one-sample history.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            samp_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            samp_q <= req;
            prev_q <= samp_q;
        end
    end

    // Edge flag and level seen by the rising-edge logic.
    always_comb begin
        level = samp_q;
        rise  = samp_q & ~prev_q;
    end

endmodule

// File: rtl/ami_mode_gate.sv
// Module: ami_mode_gate
// Decodes the static mode inputs into two decisions: may a request
// become a line violation, and should it be redirected to the system.
// Assumes: lb_mode codes outside the defined set mean no loopback.
module ami_mode_gate
    import ami_enc_pkg::*;
(
    input  logic            single_rail_en,
    input  logic            ami_en,
    input  logic            all_ones_en,
    input  logic [LB_W-1:0] lb_mode,
    output viol_gate_t      gate
);

    logic feature_on;
    logic lb_blocks;
    logic lb_digital;

    // Classify the loopback code.
    always_comb begin
        lb_digital = (lb_mode == LB_DIGITAL);
        lb_blocks  = (lb_mode == LB_ANALOG) || (lb_mode == LB_REMOTE)
                  || (lb_mode == LB_INBAND);
    end

    // Combine line coding, all-ones mode and loopback into the gate.
    always_comb begin
        feature_on     = single_rail_en & ami_en;
        gate.divert    = feature_on & all_ones_en & lb_digital;
        gate.insert_ok = feature_on & ~(all_ones_en & (lb_blocks | lb_digital));
    end

endmodule

// File: rtl/ami_mark_encoder.sv
// Module: ami_mark_encoder
// Holds the armed-violation flag and the last mark polarity, and
// registers the two line rails. Marks alternate unless a violation is
// armed; a violating mark repeats the last polarity.
// Assumes: mark_in and arm are valid at the rising edge.
module ami_mark_encoder (
    input  logic clk,
    input  logic rst_n,
    input  logic mark_in,
    input  logic arm,
    input  logic insert_ok,
    output logic line_pos,
    output logic line_neg
);

    logic pend_q;
    logic last_pos_q;  // 1: previous mark was positive
    logic pend_now;
    logic pol_now;

    // Merge new requests into the armed flag; a disabled path drops it.
    always_comb begin
        pend_now = insert_ok & (pend_q | arm);
        pol_now  = pend_now ? last_pos_q : ~last_pos_q;
    end

    // Update tracker state and register the line symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            last_pos_q <= 1'b0;
            line_pos   <= 1'b0;
            line_neg   <= 1'b0;
        end else if (mark_in) begin
            pend_q     <= 1'b0;
            last_pos_q <= pol_now;
            line_pos   <= pol_now;
            line_neg   <= ~pol_now;
        end else begin
            pend_q     <= pend_now;
            line_pos   <= 1'b0;
            line_neg   <= 1'b0;
        end
    end

endmodule

// File: rtl/ami_violation_encoder.sv
// Module: ami_violation_encoder (top)
// Single-rail to AMI dual-rail encoder with edge-triggered bipolar
// violation insertion and mode-dependent suppression or redirection.
// Assumes: mode inputs change only while rst_n is low.
module ami_violation_encoder
    import ami_enc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_data,
    input  logic            viol_req,
    input  logic            single_rail_en,
    input  logic            ami_en,
    input  logic            all_ones_en,
    input  logic [LB_W-1:0] lb_mode,
    output logic            line_pos,
    output logic            line_neg,
    output logic            viol_loop
);

    logic       req_level;
    logic       req_rise;
    logic       mark;
    viol_gate_t gate;

    ami_req_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (viol_req),
        .level (req_level),
        .rise  (req_rise)
    );

    ami_mode_gate u_gate (
        .single_rail_en (single_rail_en),
        .ami_en         (ami_en),
        .all_ones_en    (all_ones_en),
        .lb_mode        (lb_mode),
        .gate           (gate)
    );

    // All-ones mode forces every bit to a mark.
    always_comb mark = all_ones_en | tx_data;

    ami_mark_encoder u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .mark_in   (mark),
        .arm       (req_rise),
        .insert_ok (gate.insert_ok),
        .line_pos  (line_pos),
        .line_neg  (line_neg)
    );

    // Return the sampled request to the system side in redirect mode.
    always_ff @(posedge clk) begin
        if (!rst_n) viol_loop <= 1'b0;
        else        viol_loop <= gate.divert & req_level;
    end

endmodule

// File: rtl/ami_violation_encoder_chk.sv
// Module: ami_violation_encoder_chk
// Property checker bound to the top. Tracks the polarity of the last
// mark seen on the rails and checks rail exclusivity, spaces, marks,
// loopback gating, reset and forced alternation.
module ami_violation_encoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_data,
    input logic       single_rail_en,
    input logic       ami_en,
    input logic       all_ones_en,
    input logic [2:0] lb_mode,
    input logic       line_pos,
    input logic       line_neg,
    input logic       viol_loop
);

    logic seen_pos_q;
    logic redirect_m;
    logic ins_ok_m;

    // Independent mode decode for the checker.
    always_comb begin
        redirect_m = single_rail_en && ami_en && all_ones_en && (lb_mode == 3'd1);
        ins_ok_m   = single_rail_en && ami_en &&
                     !(all_ones_en && (lb_mode >= 3'd1) && (lb_mode <= 3'd4));
    end

    // Polarity of the most recent mark observed at the rails.
    always_ff @(posedge clk) begin
        if (!rst_n)                    seen_pos_q <= 1'b0;
        else if (line_pos || line_neg) seen_pos_q <= line_pos;
    end

    a_r1_rails_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_pos && line_neg));

    a_r1_space_silent: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(all_ones_en) && !$past(tx_data) |-> !line_pos && !line_neg);

    a_r2_mark_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(tx_data) |-> line_pos || line_neg);

    a_r7_all_ones_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(all_ones_en) |-> line_pos || line_neg);

    a_r8_alternate_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(ins_ok_m) && (line_pos || line_neg) |-> line_pos != seen_pos_q);

    a_r9_loop_only_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        viol_loop |-> $past(redirect_m));

    a_r10_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !line_pos && !line_neg && !viol_loop);

endmodule

bind ami_violation_encoder ami_violation_encoder_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tx_data        (tx_data),
    .single_rail_en (single_rail_en),
    .ami_en         (ami_en),
    .all_ones_en    (all_ones_en),
    .lb_mode        (lb_mode),
    .line_pos       (line_pos),
    .line_neg       (line_neg),
    .viol_loop      (viol_loop)
);

// File: tb/ami_violation_encoder_test.sv
// Bench: sweeps every mode combination with pseudo-random data and
// requests, plus directed corner cases, against an arithmetic model.
module ami_violation_encoder_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_data = 1'b0;
    logic       viol_req = 1'b0;
    logic       single_rail_en = 1'b0;
    logic       ami_en = 1'b0;
    logic       all_ones_en = 1'b0;
    logic [2:0] lb_mode = 3'd0;
    logic       line_pos;
    logic       line_neg;
    logic       viol_loop;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 0;

    // Reference model state.
    logic m_prev_r;
    logic m_last_pos;
    logic m_pend;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    ami_violation_encoder uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .tx_data        (tx_data),
        .viol_req       (viol_req),
        .single_rail_en (single_rail_en),
        .ami_en         (ami_en),
        .all_ones_en    (all_ones_en),
        .lb_mode        (lb_mode),
        .line_pos       (line_pos),
        .line_neg       (line_neg),
        .viol_loop      (viol_loop)
    );

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b (sr=%0b ami=%0b ao=%0b lb=%0d)",
                     tag, act, exp, single_rail_en, ami_en, all_ones_en, lb_mode);
        end
    endtask

    // Hold reset, check quiet outputs (R10), then release.
    task automatic do_reset();
        rst_n = 1'b0; tx_data = 1'b0; viol_req = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chk("R10", {line_pos, line_neg}, 2'b00);
        chk("R10", {1'b0, viol_loop}, 2'b00);
        m_prev_r = 1'b0; m_last_pos = 1'b0; m_pend = 1'b0;
        rst_n = 1'b1;
    endtask

    // Apply one bit period; model the result; check after the rising edge.
    task automatic step(input logic d, input logic r, input string tag_in);
        logic rise, feat, sup, div, ok, mark, viol, pol, el;
        logic [1:0] er;
        string t;
        tx_data = d; viol_req = r;
        rise = r & ~m_prev_r;
        m_prev_r = r;
        feat = single_rail_en & ami_en;
        sup  = all_ones_en && (lb_mode == 3'd2 || lb_mode == 3'd3 || lb_mode == 3'd4);
        div  = feat && all_ones_en && (lb_mode == 3'd1);
        ok   = feat & ~sup & ~div;
        m_pend = ok ? (m_pend | rise) : 1'b0;
        mark = all_ones_en | d;
        viol = 1'b0; er = 2'b00; pol = 1'b0;
        if (mark) begin
            viol = m_pend;
            pol = m_pend ? m_last_pos : ~m_last_pos;
            m_last_pos = pol;
            m_pend = 1'b0;
            er = pol ? 2'b10 : 2'b01;
        end
        el = div ? r : 1'b0;
        @(posedge clk);
        #2;
        if (tag_in != "")    t = tag_in;
        else if (!mark)      t = "R1";
        else if (viol)       t = "R4";
        else if (all_ones_en) t = "R7";
        else                 t = "R2";
        chk(t, {line_pos, line_neg}, er);
        chk("R9", {1'b0, viol_loop}, {1'b0, el});
    endtask

    task automatic set_mode(input logic sr, input logic am, input logic ao, input logic [2:0] lb);
        single_rail_en = sr; ami_en = am; all_ones_en = ao; lb_mode = lb;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        @(posedge clk);
        #2;

        // Directed: first mark positive after reset (R10), then alternation.
        set_mode(1, 1, 0, 3'd0);
        do_reset();
        step(1, 0, "R10");
        step(1, 0, "R2");
        step(0, 0, "R1");

        // R3: held-high request gives only one violation.
        step(0, 1, "R3");
        step(1, 1, "R3");
        step(1, 1, "R3");
        step(1, 1, "R3");
        step(1, 0, "R3");

        // R4: violation waits across spaces, then next mark alternates.
        step(0, 1, "R4");
        step(0, 1, "R4");
        step(0, 0, "R4");
        step(1, 0, "R4");
        step(1, 0, "R4");

        // R5: two edges before a mark merge into one violation.
        step(0, 1, "R5");
        step(0, 0, "R5");
        step(0, 1, "R5");
        step(1, 0, "R5");
        step(1, 0, "R5");
        step(1, 0, "R5");

        // R6: insertion off when ami_en is low.
        set_mode(1, 0, 0, 3'd0);
        do_reset();
        step(0, 1, "R6");
        step(1, 0, "R6");
        step(1, 0, "R6");

        // R8: all-ones with remote loopback drops requests.
        set_mode(1, 1, 1, 3'd3);
        do_reset();
        step(0, 1, "R8");
        step(0, 0, "R8");
        step(0, 1, "R8");
        step(1, 0, "R8");

        // R9: all-ones with digital loopback redirects the request.
        set_mode(1, 1, 1, 3'd1);
        do_reset();
        step(0, 1, "R9");
        step(0, 1, "R9");
        step(0, 0, "R9");

        // Sweep all mode combinations, including reserved loopback codes.
        for (int sr = 0; sr < 2; sr++) begin
            for (int am = 0; am < 2; am++) begin
                for (int ao = 0; ao < 2; ao++) begin
                    for (int lb = 0; lb < 8; lb++) begin
                        set_mode(sr[0], am[0], ao[0], lb[2:0]);
                        do_reset();
                        for (int k = 0; k < 48; k++) begin
                            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                            step(lfsr[0], lfsr[3] & lfsr[7], "");
                        end
                    end
                end
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule